// File: doc/BRIEF.md
# Iterative Grid Removal Solver

The solver holds a binary occupancy grid of `ROWS` rows by `COLS` columns and repeatedly strips away every occupied cell that is too lightly surrounded, until a whole sweep leaves the grid unchanged. The grid arrives as a stream of cell vectors, `VEC` cells per beat, in row-major order. It is parked in an on-chip recirculating queue. Each sweep pulls every beat out of the queue and pushes it through a three-row sliding window. The survivors of each centre beat are written back into the same queue, ready for the next sweep.

Each beat carries boundary tags: first row, last row, first beat of a row and last beat of a row. The tags are regenerated from a position counter every time the beat leaves the queue, and they travel beside the data through the window. Neighbours outside the grid therefore always read as empty, whichever sweep is running. A sweep ends when the bottom-right beat leaves the window centre. The removals of that sweep are then added to a running total. If the sweep removed nothing, the solver stops and raises `done`.

Top module: `grid_solver`

## Requirements
- R1: After reset `busy`=0, `done`=0, `total`=0 and `loadReady`=1.
- R2: `loadReady` is high only while the solver is idle and holds fewer than ROWS*COLS/VEC beats. A beat is taken when `loadValid` and `loadReady` are both high. Beat b covers row b/(COLS/VEC). Its bit i is the cell at column (b mod (COLS/VEC))*VEC+i. A 1 marks an occupied cell.
- R3: `start` is ignored, and `busy` stays low, unless the full grid of ROWS*COLS/VEC beats has been loaded.
- R4: In a sweep, an occupied cell is cleared when fewer than `THRESH` of its eight neighbours are occupied. Cells outside the grid count as empty. The last cell of a row is not adjacent to the first cell of the next row. All cells of a sweep are judged on the grid as it stood before that sweep.
- R5: Sweeps repeat. At the edge that ends each sweep, `total` grows by the number of cells that sweep removed, and it is constant during a sweep. It is cleared when a run starts.
- R6: After the first sweep that removes no cell, `done` rises and `busy` falls on the same edge. From then on `done` stays high, `total` is stable and `start` has no effect until reset.
- R7: Every sweep lasts exactly ROWS*COLS/VEC + COLS/VEC + 2 cycles and sweeps follow back to back. `busy` is therefore high for that many cycles times the number of sweeps, including the final empty one.
- R8: The window is emptied between sweeps, so beats of two sweeps never meet in one neighbourhood.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Load beat present |
| loadData | input | VEC | Load beat cells, bit i = leftmost+i |
| loadReady | output | 1 | Solver accepts a load beat |
| start | input | 1 | Begin solving the loaded grid |
| busy | output | 1 | Sweeps in progress |
| done | output | 1 | Fixed point reached |
| total | output | TOT_W | Cells removed so far |

## Verification
The bench feeds grids whose answer depends on row edges. Two full edge columns must vanish in a single sweep. A design that let a row's last beat see the next row's first beat would keep some of those cells and report a smaller total. Dense and random grids take several sweeps. A design whose total folded in removals mid-sweep, mixed stale window rows into a new sweep, or added a drain cycle per sweep would miss the expected total on a specific cycle or the exact length of `busy`. An empty grid, a partly loaded grid and a finished solver all receive `start` pulses. A design that started on an incomplete queue would raise `busy` where it must stay low.

// File: rtl/grid_solver_pkg.sv
package grid_solver_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN,
    S_DONE
  } solverState_t;

  // sideband tags that travel beside every beat in the window
  typedef struct packed {
    logic vld;
    logic topRow;
    logic botRow;
    logic leftBeat;
    logic rightBeat;
  } beatTag_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic     loadPush;
    logic     feedPop;
    logic     shift;
    logic     passEnd;
    logic     clearTotal;
    beatTag_t tag;
  } ctlStrobe_t;

endpackage

// File: rtl/solver_ctl.sv
module solver_ctl
  import grid_solver_pkg::*;
#(
  parameter int ROWS = 6,
  parameter int BPR  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       loadValid,
  input  logic       fifoFull,
  input  logic       centreLast,
  input  logic       passZero,
  output ctlStrobe_t strb,
  output logic       busy,
  output logic       done,
  output logic       loadReady
);
  localparam int N   = ROWS * BPR;
  localparam int FW  = $clog2(N + 1);
  localparam int RW  = $clog2(ROWS + 1);
  localparam int CBW = $clog2(BPR + 1);
  localparam logic [FW-1:0]  FEED_END = FW'(N);
  localparam logic [RW-1:0]  ROW_LAST = RW'(ROWS - 1);
  localparam logic [CBW-1:0] COL_LAST = CBW'(BPR - 1);

  solverState_t   st;
  logic [FW-1:0]  feedCnt;
  logic [RW-1:0]  rowIdx;
  logic [CBW-1:0] colIdx;
  logic           feeding;

  assign feeding = (st == S_RUN) && (feedCnt != FEED_END);
  assign busy    = (st == S_RUN);
  assign done    = (st == S_DONE);

  always_comb begin
    strb               = '0;
    loadReady          = (st == S_IDLE) && !fifoFull;
    strb.loadPush      = loadValid && loadReady;
    strb.clearTotal    = (st == S_IDLE) && start && fifoFull;
    strb.shift         = (st == S_RUN);
    strb.passEnd       = (st == S_RUN) && centreLast;
    strb.feedPop       = feeding;
    strb.tag.vld       = feeding;
    strb.tag.topRow    = feeding && (rowIdx == '0);
    strb.tag.botRow    = feeding && (rowIdx == ROW_LAST);
    strb.tag.leftBeat  = feeding && (colIdx == '0);
    strb.tag.rightBeat = feeding && (colIdx == COL_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= S_IDLE;
      feedCnt <= '0;
      rowIdx  <= '0;
      colIdx  <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          feedCnt <= '0;
          rowIdx  <= '0;
          colIdx  <= '0;
          if (strb.clearTotal) st <= S_RUN;
        end
        S_RUN: begin
          if (centreLast) begin
            feedCnt <= '0;
            rowIdx  <= '0;
            colIdx  <= '0;
            if (passZero) st <= S_DONE;
          end else if (feeding) begin
            feedCnt <= feedCnt + FW'(1);
            if (colIdx == COL_LAST) begin
              colIdx <= '0;
              rowIdx <= rowIdx + RW'(1);
            end else begin
              colIdx <= colIdx + CBW'(1);
            end
          end
        end
        default: st <= S_DONE;
      endcase
    end
  end

  // R3: a start without a full grid leaves the solver idle
  p_start_needs_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_IDLE && start && !fifoFull) |=> (st == S_IDLE));

  // R6: the finished state is kept
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_DONE) |=> (st == S_DONE));

  // R7: the datapath sees the last beat only once every data beat has been fed
  p_feed_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_RUN && centreLast) |-> (feedCnt == FEED_END));

endmodule

// File: rtl/solver_dp.sv
module solver_dp
  import grid_solver_pkg::*;
#(
  parameter int ROWS   = 6,
  parameter int BPR    = 2,
  parameter int VEC    = 4,
  parameter int THRESH = 4,
  parameter int TOT_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  input  logic [VEC-1:0]   loadData,
  output logic             fifoFull,
  output logic             centreLast,
  output logic             passZero,
  output logic [TOT_W-1:0] total
);
  localparam int N     = ROWS * BPR;
  localparam int AW    = $clog2(N);
  localparam int CW    = $clog2(N + 1);
  localparam int DEPTH = 2 * BPR + 3;
  localparam int CTR   = BPR + 1;
  localparam int RCW   = $clog2(VEC + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(N - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(N);

  // recirculating queue
  logic [VEC-1:0] mem [N];
  logic [AW-1:0]  rdPtr, wrPtr;
  logic [CW-1:0]  count;
  logic           pushEn, popEn;
  logic [VEC-1:0] pushData, head;

  // sliding window
  logic [VEC-1:0] cellSr [DEPTH];
  beatTag_t       tagSr  [DEPTH];
  beatTag_t       ct;
  logic [VEC+1:0] upW, midW, dnW;
  logic [VEC-1:0] rm, wbCells;
  logic           wbValid;
  logic [RCW-1:0] beatRem;
  logic [TOT_W-1:0] passCnt, passSum;
  logic [DEPTH-1:0] vldVec;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    if (p == PTR_LAST) return '0;
    return p + AW'(1);
  endfunction

  function automatic logic [VEC+1:0] edgeRow(input logic [VEC-1:0] l, input logic [VEC-1:0] m,
                                             input logic [VEC-1:0] r, input logic useL,
                                             input logic useR);
    return {r[0] & useR, m, l[VEC-1] & useL};
  endfunction

  assign head     = mem[rdPtr];
  assign popEn    = strb.feedPop;
  assign pushEn   = strb.loadPush | wbValid;
  assign pushData = strb.loadPush ? loadData : wbCells;
  assign fifoFull = (count == CNT_FULL);

  always_ff @(posedge clk) begin
    if (pushEn) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (pushEn) wrPtr <= nextPtr(wrPtr);
      if (popEn)  rdPtr <= nextPtr(rdPtr);
      unique case ({pushEn, popEn})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.passEnd) begin
      for (int k = 0; k < DEPTH; k++) begin
        cellSr[k] <= '0;
        tagSr[k]  <= '0;
      end
    end else if (strb.shift) begin
      cellSr[0] <= popEn ? head : '0;
      tagSr[0]  <= strb.tag;
      for (int k = 1; k < DEPTH; k++) begin
        cellSr[k] <= cellSr[k-1];
        tagSr[k]  <= tagSr[k-1];
      end
    end
  end

  assign ct      = tagSr[CTR];
  assign wbValid = ct.vld;

  always_comb begin
    upW  = ct.topRow ? '0 : edgeRow(cellSr[2*BPR+2], cellSr[2*BPR+1], cellSr[2*BPR],
                                    !ct.leftBeat, !ct.rightBeat);
    midW = edgeRow(cellSr[BPR+2], cellSr[BPR+1], cellSr[BPR], !ct.leftBeat, !ct.rightBeat);
    dnW  = ct.botRow ? '0 : edgeRow(cellSr[2], cellSr[1], cellSr[0],
                                    !ct.leftBeat, !ct.rightBeat);
  end

  for (genvar i = 0; i < VEC; i++) begin : g_cell
    assign rm[i] = midW[i+1] &&
                   ($countones({upW[i+2:i], midW[i], midW[i+2], dnW[i+2:i]}) < THRESH);
  end

  assign wbCells    = cellSr[CTR] & ~rm;
  assign beatRem    = ct.vld ? RCW'($countones(rm)) : '0;
  assign passSum    = passCnt + TOT_W'(beatRem);
  assign passZero   = (passSum == '0);
  assign centreLast = ct.vld && ct.botRow && ct.rightBeat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      passCnt <= '0;
      total   <= '0;
    end else if (strb.clearTotal) begin
      passCnt <= '0;
      total   <= '0;
    end else if (strb.passEnd) begin
      passCnt <= '0;
      total   <= total + passSum;
    end else if (wbValid) begin
      passCnt <= passSum;
    end
  end

  always_comb begin
    for (int k = 0; k < DEPTH; k++) vldVec[k] = tagSr[k].vld;
  end

  // R2: the queue never takes more than one grid
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !popEn) |-> (count != CNT_FULL));

  // R5: a sweep only pulls beats that exist
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    popEn |-> (count != '0));

  // R8: nothing of a finished sweep remains in the window
  p_window_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.passEnd |=> (vldVec == '0));

endmodule

// File: rtl/grid_solver.sv
module grid_solver
  import grid_solver_pkg::*;
#(
  parameter int ROWS   = 6,
  parameter int COLS   = 8,
  parameter int VEC    = 4,
  parameter int THRESH = 4,
  parameter int TOT_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadValid,
  input  logic [VEC-1:0]   loadData,
  output logic             loadReady,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [TOT_W-1:0] total
);
  localparam int BPR = COLS / VEC;

  ctlStrobe_t strb;
  logic       fifoFull, centreLast, passZero;

  solver_ctl #(.ROWS(ROWS), .BPR(BPR)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .loadValid(loadValid),
    .fifoFull(fifoFull), .centreLast(centreLast), .passZero(passZero),
    .strb(strb), .busy(busy), .done(done), .loadReady(loadReady)
  );

  solver_dp #(.ROWS(ROWS), .BPR(BPR), .VEC(VEC), .THRESH(THRESH), .TOT_W(TOT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadData(loadData),
    .fifoFull(fifoFull), .centreLast(centreLast), .passZero(passZero), .total(total)
  );

  // R6: the reported total is frozen once finished
  p_total_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> $stable(total));

endmodule

// File: tb/grid_solver_test.sv
module grid_solver_test;
  localparam int ROWS   = 6;
  localparam int COLS   = 8;
  localparam int VEC    = 4;
  localparam int THRESH = 4;
  localparam int TOT_W  = 16;
  localparam int BPR    = COLS / VEC;
  localparam int N      = ROWS * BPR;
  localparam int L      = N + BPR + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadValid = 1'b0;
  logic start = 1'b0;
  logic [VEC-1:0] loadData = '0;
  logic loadReady, busy, done;
  logic [TOT_W-1:0] total;

  always #4 clk = ~clk;

  grid_solver #(.ROWS(ROWS), .COLS(COLS), .VEC(VEC), .THRESH(THRESH), .TOT_W(TOT_W)) uut (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadData(loadData),
    .loadReady(loadReady), .start(start), .busy(busy), .done(done), .total(total)
  );

  int checks = 0;
  int fails = 0;
  bit g [ROWS][COLS];
  bit ng [ROWS][COLS];
  int cumBefore [64];
  int passes;
  int grand;
  logic [31:0] lfsr;

  task automatic checkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; loadValid = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1", "busy after reset", int'(busy), 0);
    checkEq("R1", "done after reset", int'(done), 0);
    checkEq("R1", "total after reset", int'(total), 0);
    checkEq("R1", "loadReady after reset", int'(loadReady), 1);
  endtask

  task automatic loadBeats(int first, int cnt);
    for (int b = first; b < first + cnt; b++) begin
      checkEq("R2", "loadReady while filling", int'(loadReady), 1);
      loadValid = 1'b1;
      for (int i = 0; i < VEC; i++) loadData[i] = g[b / BPR][(b % BPR) * VEC + i];
      @(negedge clk);
    end
    loadValid = 1'b0;
  endtask

  task automatic pokeStart(string req);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      checkEq(req, "busy after ignored start", int'(busy), 0);
      @(negedge clk);
    end
  endtask

  task automatic modelSolve();
    int rem;
    passes = 0; grand = 0;
    do begin
      rem = 0;
      cumBefore[passes] = grand;
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          int nb = 0;
          ng[r][c] = g[r][c];
          for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++)
              if ((dr != 0 || dc != 0) && r + dr >= 0 && r + dr < ROWS &&
                  c + dc >= 0 && c + dc < COLS && g[r+dr][c+dc])
                nb++;
          if (g[r][c] && nb < THRESH) begin
            ng[r][c] = 1'b0;
            rem++;
          end
        end
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) g[r][c] = ng[r][c];
      grand += rem;
      passes++;
    end while (rem != 0);
  endtask

  task automatic runAndCheck(string req);
    modelSolve();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < passes * L; j++) begin
      checkEq("R7", "busy during sweeps", int'(busy), 1);
      checkEq("R6", "done during sweeps", int'(done), 0);
      checkEq("R5", "total during sweep", int'(total), cumBefore[j / L]);
      @(negedge clk);
    end
    checkEq("R7", "busy after last sweep", int'(busy), 0);
    checkEq("R6", "done after last sweep", int'(done), 1);
    checkEq(req, "final total", int'(total), grand);
    start = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      checkEq("R6", "done held", int'(done), 1);
      checkEq("R6", "total held", int'(total), grand);
      checkEq("R6", "busy stays low", int'(busy), 0);
      checkEq("R2", "no load when finished", int'(loadReady), 0);
    end
    start = 1'b0;
  endtask

  task automatic fillGrid(int mode, int dens);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        case (mode)
          0: g[r][c] = 1'b0;
          1: g[r][c] = 1'b1;
          2: g[r][c] = (c == 0 || c == COLS - 1);
          default: g[r][c] = (int'(lfsr % 8) < dens);
        endcase
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired act=%0d exp=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    lfsr = 32'h1234_5677;

    // empty grid: one sweep, nothing removed (R4, R7); start before load ignored (R3)
    doReset();
    fillGrid(0, 0);
    pokeStart("R3");
    loadBeats(0, N);
    checkEq("R2", "loadReady when full", int'(loadReady), 0);
    runAndCheck("R4");

    // two edge columns: no row wrap, all removed in one sweep (R4); partial load (R3)
    doReset();
    fillGrid(2, 0);
    loadBeats(0, 5);
    pokeStart("R3");
    loadBeats(5, N - 5);
    checkEq("R2", "loadReady when full", int'(loadReady), 0);
    runAndCheck("R4");

    // fully occupied grid: several sweeps (R5)
    doReset();
    fillGrid(1, 0);
    loadBeats(0, N);
    runAndCheck("R5");

    // random grids of varied density: sweeps must not mix (R8)
    for (int d = 3; d <= 7; d += 2) begin
      doReset();
      fillGrid(3, d);
      loadBeats(0, N);
      runAndCheck("R8");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule